// File: doc/BRIEF.md
# Gated Period Pulse Counter

This block counts rising edges on an asynchronous pulse input over a gate window of fixed length. When a window closes, the total is copied into a 32-bit result register, the running count starts again from zero, and a status bit inverts. The host therefore learns that a new result is ready by comparing that bit with the copy it saw last. The window length is set in system clock cycles by a parameter. Its default, 500,000,000 cycles, equals 10 s at 50 MHz.

The host drives an 8-bit control byte and reads an 8-bit status byte. One control bit enables periodic counting. Two other control bits drive two discrete outputs. The status byte reports whether counting is running, the levels of the two outputs, the synchronized level of a direction input and the new-result toggle. Clearing the enable bit stops counting and resets the window. The last result is kept.

Top module: `period_pulse_counter`

## Requirements
- R1: The pulse input is synchronized through two flops and its rising edges are counted. Once windows are running steadily, each window covers `GATE_CYCLES` consecutive clock cycles and the result equals the number of rising edges in that window.
- R2: `count_out` changes only in the cycle after a window closes. At all other times it holds its last value.
- R3: After each capture the running count restarts from zero. A rising edge that is detected on the closing cycle of a window is counted in the next window.
- R4: Control bit 5 enables periodic counting. Status bit 5 equals control bit 5 as it was one clock earlier.
- R5: Status bit 0 inverts exactly once for each window that closes, in the same cycle that the new result appears.
- R6: Control bit 2 drives `aux_out_a` and control bit 3 drives `aux_out_b`, each one clock later. Status bits 2 and 3 report the levels of `aux_out_a` and `aux_out_b`.
- R7: Status bit 1 equals `dir_in` after a two-flop synchronizer.
- R8: While control bit 5 is clear, the window timer and the running count are held at zero, the first window starts over when the bit is set again, and neither `count_out` nor status bit 0 changes.
- R9: Synchronous reset clears `count_out`, the status byte and both discrete outputs to zero.
- R10: Status bits 7, 6 and 4 always read zero. Control bits 7, 6, 4, 1 and 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Asynchronous pulse input whose rising edges are counted |
| dir_in | input | 1 | Asynchronous direction level, reported in the status byte |
| ctrl_in | input | 8 | Control byte: bit 5 enable, bit 2 output A, bit 3 output B |
| status_out | output | 8 | Status byte: bit 5 running, bits 3/2 output levels, bit 1 direction, bit 0 new-result toggle |
| count_out | output | CNT_W | Latched edge count of the last completed window |
| aux_out_a | output | 1 | Discrete output A |
| aux_out_b | output | 1 | Discrete output B |

## Verification
The case that is hardest to reach from the ports is a rising edge that is detected exactly on the closing cycle of a window. That edge must be counted in the new window and must be missing from the captured total. The bench shortens the window to 40 cycles and drives a pulse train with a period of 3. Because 3 and 40 share no factor, the edge phase walks across every position in the window, including the boundary cycle. A per-cycle reference model then confirms every capture. The bench also stops and restarts counting in the middle of a window, to show that the result is kept and that the window starts over.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    // control byte positions the block acts on
    localparam int CTRL_RUN_BIT = 5;
    localparam int CTRL_AUXB_BIT = 3;
    localparam int CTRL_AUXA_BIT = 2;

    typedef struct packed {
        logic run;
        logic aux_b;
        logic aux_a;
    } ctrl_t;

    // status byte, msb first
    typedef struct packed {
        logic [1:0] zero_hi;
        logic       started;
        logic       zero_mid;
        logic       lvl_b;
        logic       lvl_a;
        logic       dir;
        logic       fresh;
    } status_t;

    function automatic ctrl_t decode_ctrl(input logic [7:0] b);
        ctrl_t c;
        c.run   = b[CTRL_RUN_BIT];
        c.aux_b = b[CTRL_AUXB_BIT];
        c.aux_a = b[CTRL_AUXA_BIT];
        return c;
    endfunction

    function automatic status_t pack_status(input logic started, input logic lvl_b,
                                            input logic lvl_a, input logic dir,
                                            input logic fresh);
        status_t s;
        s.zero_hi  = 2'b00;
        s.started  = started;
        s.zero_mid = 1'b0;
        s.lvl_b    = lvl_b;
        s.lvl_a    = lvl_a;
        s.dir      = dir;
        s.fresh    = fresh;
        return s;
    endfunction

endpackage

// File: rtl/ppc_edge_sync.sv
module ppc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    // STAGES synchronizer flops plus one history flop for edge detect
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= async_in;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~chain[STAGES];

    // R1: a detected edge is a single-cycle event
    a_r1_rise_single: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/ppc_gate_timer.sv
module ppc_gate_timer #(
    parameter int GATE_CYCLES = 500_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic wrap
);
    localparam int TW = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(GATE_CYCLES - 1);

    logic [TW-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst || !run)   tick <= '0;
        else if (tick == LAST) tick <= '0;
        else               tick <= tick + TW'(1);
    end

    assign wrap = run && (tick == LAST);

    // R1: the timer never leaves its window range
    a_r1_tick_range: assert property (@(posedge clk) disable iff (rst)
        tick <= LAST);
    // R8: an idle timer sits at zero
    a_r8_tick_idle: assert property (@(posedge clk) disable iff (rst)
        !run |=> tick == '0);

endmodule

// File: rtl/ppc_accum.sv
module ppc_accum #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             wrap,
    input  logic             rise,
    output logic [CNT_W-1:0] result,
    output logic             fresh
);
    logic [CNT_W-1:0] live;

    always_ff @(posedge clk) begin
        if (rst) begin
            live   <= '0;
            result <= '0;
            fresh  <= 1'b0;
        end else if (!run) begin
            live <= '0;
        end else if (wrap) begin
            result <= live;
            live   <= {{(CNT_W-1){1'b0}}, rise};
            fresh  <= ~fresh;
        end else if (rise) begin
            live <= live + CNT_W'(1);
        end
    end

    // R5: the toggle flips on every window close
    a_r5_toggle_on_wrap: assert property (@(posedge clk) disable iff (rst)
        wrap |=> fresh != $past(fresh));
    // R2: the result and the toggle hold between closes
    a_r2_result_hold: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(result) && $stable(fresh));
    // R3: the new window starts from zero or from the boundary edge
    a_r3_restart: assert property (@(posedge clk) disable iff (rst)
        wrap |=> live <= CNT_W'(1));
    // R8: the running count is cleared while idle
    a_r8_live_idle: assert property (@(posedge clk) disable iff (rst)
        !run |=> live == '0);

endmodule

// File: rtl/period_pulse_counter.sv
module period_pulse_counter
    import ppc_pkg::*;
#(
    parameter int GATE_CYCLES = 500_000_000,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_in,
    input  logic             dir_in,
    input  logic [7:0]       ctrl_in,
    output logic [7:0]       status_out,
    output logic [CNT_W-1:0] count_out,
    output logic             aux_out_a,
    output logic             aux_out_b
);
    ctrl_t   ctl;
    status_t sts;
    logic    run_q;
    logic    pulse_rise;
    logic    pulse_lvl_unused;
    logic    dir_lvl;
    logic    dir_rise_unused;
    logic    wrap;
    logic    fresh;
    logic    ctrl_unused;

    assign ctl = decode_ctrl(ctrl_in);
    assign ctrl_unused = ^{ctrl_in[7:6], ctrl_in[4], ctrl_in[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            aux_out_a <= 1'b0;
            aux_out_b <= 1'b0;
        end else begin
            run_q     <= ctl.run;
            aux_out_a <= ctl.aux_a;
            aux_out_b <= ctl.aux_b;
        end
    end

    ppc_edge_sync #(.STAGES(SYNC_STAGES)) u_pulse_sync (
        .clk(clk), .rst(rst), .async_in(pulse_in),
        .level(pulse_lvl_unused), .rise(pulse_rise)
    );

    ppc_edge_sync #(.STAGES(SYNC_STAGES)) u_dir_sync (
        .clk(clk), .rst(rst), .async_in(dir_in),
        .level(dir_lvl), .rise(dir_rise_unused)
    );

    ppc_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .run(run_q), .wrap(wrap)
    );

    ppc_accum #(.CNT_W(CNT_W)) u_accum (
        .clk(clk), .rst(rst), .run(run_q), .wrap(wrap), .rise(pulse_rise),
        .result(count_out), .fresh(fresh)
    );

    assign sts = pack_status(run_q, aux_out_b, aux_out_a, dir_lvl, fresh);
    assign status_out = sts;

    // R4: the running flag follows the enable bit one clock later
    a_r4_started: assert property (@(posedge clk) disable iff (rst)
        !rst |=> status_out[5] == $past(ctrl_in[5]));
    // R6: the discrete outputs follow their control bits one clock later
    a_r6_aux_follow: assert property (@(posedge clk) disable iff (rst)
        !rst |=> aux_out_a == $past(ctrl_in[2]) && aux_out_b == $past(ctrl_in[3]));
    // R8: when stopped, the result is frozen
    a_r8_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        !status_out[5] |=> $stable(count_out));

endmodule

// File: tb/period_pulse_counter_test.sv
module period_pulse_counter_test;
    localparam int CLK_PERIOD = 10;
    localparam int GATE = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pulse_in = 1'b0;
    logic        dir_in = 1'b0;
    logic [7:0]  ctrl_in = 8'h00;
    logic [7:0]  status_out;
    logic [31:0] count_out;
    logic        aux_out_a, aux_out_b;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;

    period_pulse_counter #(.GATE_CYCLES(GATE), .CNT_W(32)) uut (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .dir_in(dir_in),
        .ctrl_in(ctrl_in), .status_out(status_out), .count_out(count_out),
        .aux_out_a(aux_out_a), .aux_out_b(aux_out_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: input sample history plus window bookkeeping
    bit          ph[4];
    bit          dh[2];
    bit          m_run, m_tog, m_a, m_b;
    int          m_tick;
    logic [31:0] m_live, m_res;

    always @(posedge clk) begin
        bit e;
        if (rst) begin
            foreach (ph[i]) ph[i] = 0;
            dh[0] = 0; dh[1] = 0;
            m_run = 0; m_tog = 0; m_a = 0; m_b = 0;
            m_tick = 0; m_live = 0; m_res = 0;
        end else begin
            ph[3] = ph[2]; ph[2] = ph[1]; ph[1] = ph[0]; ph[0] = pulse_in;
            dh[1] = dh[0]; dh[0] = dir_in;
            e = ph[2] && !ph[3];
            if (!m_run) begin
                m_tick = 0; m_live = 0;
            end else if (m_tick == GATE - 1) begin
                m_res = m_live; m_live = e ? 1 : 0; m_tog = !m_tog; m_tick = 0;
            end else begin
                m_tick++; if (e) m_live++;
            end
            m_run = ctrl_in[5]; m_a = ctrl_in[2]; m_b = ctrl_in[3];
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 R3 count_out", count_out, m_res);
            check("R5 status bit0", 32'(status_out[0]), 32'(m_tog));
            check("R4 status bit5", 32'(status_out[5]), 32'(m_run));
            check("R6 aux outputs", {30'd0, aux_out_b, aux_out_a}, {30'd0, m_b, m_a});
            check("R6 status bits3:2", 32'(status_out[3:2]), {30'd0, m_b, m_a});
            check("R7 status bit1", 32'(status_out[1]), 32'(dh[1]));
            check("R10 reserved bits", {29'd0, status_out[7:6], status_out[4]}, 32'd0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            summary();
        end
    end

    // mode 0 idle, 1 period 4, 2 period 3, 3 pseudo-random
    task automatic drive(int n, int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (mode)
                1: pulse_in = (i % 4) < 2;
                2: pulse_in = (i % 3) == 0;
                3: pulse_in = lfsr[0];
                default: pulse_in = 1'b0;
            endcase
            if (mode == 3) dir_in = lfsr[5];
        end
    endtask

    logic [31:0] held;

    initial begin
        rst = 1'b1;
        ctrl_in = 8'hFF;
        pulse_in = 1'b1;
        dir_in = 1'b1;
        repeat (4) @(negedge clk);
        // R9: reset state
        check("R9 count_out reset", count_out, 32'd0);
        check("R9 status reset", 32'(status_out), 32'd0);
        check("R9 aux reset", {30'd0, aux_out_b, aux_out_a}, 32'd0);
        ctrl_in = 8'h00; pulse_in = 1'b0; dir_in = 1'b0;
        @(negedge clk); rst = 1'b0;
        drive(20, 0);

        // R1: period-4 pulses give 10 edges per 40-cycle window
        ctrl_in = 8'h20;
        drive(400, 1);
        check("R1 steady count", count_out, 32'd10);

        // R3: period-3 phase walk places edges on the boundary cycle
        drive(600, 2);
        check("R3 boundary count low", 32'(count_out >= 13), 32'd1);
        check("R3 boundary count high", 32'(count_out <= 14), 32'd1);

        // R8 and R10: stop mid-window with junk bits, outputs on
        drive(17, 3);
        held = count_out;
        ctrl_in = 8'hDF & ~8'h20;
        drive(200, 3);
        check("R8 result kept when stopped", count_out, held);
        check("R8 stopped flag", 32'(status_out[5]), 32'd0);

        // R6/R10: outputs with the enable and junk bits set
        ctrl_in = 8'hF7;
        drive(300, 3);
        ctrl_in = 8'h2C;
        drive(500, 3);
        ctrl_in = 8'h00;
        drive(30, 1);
        ctrl_in = 8'h24;
        drive(500, 1);
        check("R1 steady count after restart", count_out, 32'd10);
        drive(10, 0);
        summary();
    end

endmodule